// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real address by walking an in-memory radix tree. A walk starts when the requester pulses a request with the address and a process identifier. The walker first bounds the identifier against the configured process-table size. It then reads that process's table entry, which gives the total number of translated address bits, the root directory base and the root index width. After that it reads one 8-byte entry per level until it reaches a leaf.

Each directory entry names the base and the index width of the next level. The shape of the tree therefore comes from memory contents and not from the hardware, and the page size is whatever part of the translated size is left when the leaf is found. All reads go through a single request/response port. The walker holds the request and its address until the response arrives. A walk ends with a one-cycle done pulse and the translation results, or with a one-cycle fault pulse and a cause code. Permission checks are left to the consumer of the leaf entry.

Top module: `rw_radix_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are low, and `mem_req` is never high while `busy` is low.
- R2: With size code f, the process table holds 2^(f+12) bytes and each entry is PTE_BYTES (16) bytes. If pid×16 is at or above the table size, a no-entry fault pulses in the cycle after the request and no memory read happens. Otherwise the first read goes to `ptab_base` + pid×16.
- R3: The process-table entry is decoded as follows: bits [61:56] give the total translated size, bits [55:8] (with bits [7:0] taken as zero) give the root directory base, and bits [4:0] give the root index width.
- R4: At each level the entry read goes to base + 8×((ea >> (rem − n)) & (2^n − 1)), where rem is the remaining size and n is the level's index width.
- R5: A level whose index width is below 5, or above the remaining size, ends the walk with a bad-configuration fault before that level is read.
- R6: A level entry with bit 63 (valid) clear ends the walk with a no-entry fault.
- R7: A valid entry with bit 62 (leaf) set pulses `done`. It sets `page_shift` = rem − n and `leaf_entry` = the entry, and `leaf_addr` = the entry's address. It sets `real_addr` = (entry bits [55:12], with bits [11:0] taken as zero) on the bits at and above `page_shift`, and the effective address on the bits below `page_shift`.
- R8: A valid non-leaf entry supplies the next base from bits [55:8] and the next index width from bits [4:0], and it reduces the remaining size by n.
- R9: At most MAX_LEVELS (8) directory reads follow the process-table read. Needing another read raises a bad-configuration fault.
- R10: One walk runs at a time. `busy` is high from the cycle after acceptance until the cycle `done` or `fault` pulses, and a request while busy is ignored. `mem_req` and `mem_addr` hold steady until `mem_rvalid`.
- R11: `done` and `fault` are single-cycle pulses and never high together. `fault_cause` is one-hot: bit 0 means no entry and bit 1 means bad configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (accepted while idle) |
| req_ea | input | 64 | Effective address to translate |
| req_pid | input | PID_W | Process identifier |
| ptab_base | input | 64 | Process table base address |
| ptab_size | input | 5 | Process table size code f (2^(f+12) bytes) |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | 64 | Memory read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read response data |
| done | output | 1 | Translation complete pulse |
| fault | output | 1 | Walk failed pulse |
| fault_cause | output | 2 | One-hot fault cause |
| real_addr | output | 64 | Translated real address |
| page_shift | output | 6 | Page size exponent |
| leaf_entry | output | 64 | Leaf entry as read |
| leaf_addr | output | 64 | Address of the leaf entry |

## Verification
The bench places the PID at both sides of the table bound. An off-by-one compare would read past the table, or would fault on the last legal entry. It also drives index widths of 4 and wider than the remaining size, at the root and deeper in the tree: a walker that skips these checks would issue reads with a negative shift and land on bogus addresses. A chain of exactly eight directories is run in two forms. When it ends in a leaf it must translate with a 23-bit page. When it does not, it must fault after exactly nine reads, which exposes an off-by-one level limit. A mid-walk request and a large-page leaf catch a walker that restarts when busy, or one that merges the page number at a fixed 4 KiB boundary.

// File: rtl/rw_pkg.sv
package rw_pkg;
   localparam int ENTRY_W   = 64;
   localparam int SZ_W      = 6;
   localparam int IDXW_W    = 5;
   localparam int CAUSE_W   = 2;
   localparam int ENT_LOG2  = 3;

   localparam int VALID_BIT = 63;
   localparam int LEAF_BIT  = 62;
   localparam int BASE_LSB  = 8;
   localparam int BASE_MSB  = 55;
   localparam int PN_LSB    = 12;
   localparam int TOT_LSB   = 56;

   localparam logic [ENTRY_W-1:0] BASE_MASK =
      ((ENTRY_W'(1) << (BASE_MSB + 1)) - ENTRY_W'(1)) & ~((ENTRY_W'(1) << BASE_LSB) - ENTRY_W'(1));
   localparam logic [ENTRY_W-1:0] PN_MASK =
      ((ENTRY_W'(1) << (BASE_MSB + 1)) - ENTRY_W'(1)) & ~((ENTRY_W'(1) << PN_LSB) - ENTRY_W'(1));

   localparam logic [CAUSE_W-1:0] CAUSE_NOENT  = 2'b01;
   localparam logic [CAUSE_W-1:0] CAUSE_BADCFG = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PTAB,
      ST_CHECK,
      ST_LEVEL
   } walk_state_t;
endpackage

// File: rtl/rw_ptab_bound.sv
module rw_ptab_bound #(
   parameter int PID_W    = 20,
   parameter int PTE_LOG2 = 4,
   parameter int ADDR_W   = 64
) (
   input  logic [PID_W-1:0]  pid,
   input  logic [4:0]        size_code,
   output logic              in_range,
   output logic [ADDR_W-1:0] offset
);
   localparam int SH_BASE = 12 - PTE_LOG2;

   generate
      if (PTE_LOG2 > 12) begin : g_bad_log2
         $error("rw_ptab_bound: entry size above 4 KiB");
      end
      if (PID_W + PTE_LOG2 > ADDR_W) begin : g_bad_pid
         $error("rw_ptab_bound: PID offset wider than address");
      end
   endgenerate

   logic [6:0] shamt;

   always_comb begin
      shamt    = 7'(size_code) + 7'(SH_BASE);
      in_range = ((ADDR_W'(pid) >> shamt) == '0);
      offset   = ADDR_W'(pid) << PTE_LOG2;
   end
endmodule

// File: rtl/rw_index_gen.sv
module rw_index_gen #(
   parameter int ADDR_W   = 64,
   parameter int SZ_W     = 6,
   parameter int IDXW_W   = 5,
   parameter int ENT_LOG2 = 3
) (
   input  logic [ADDR_W-1:0] ea,
   input  logic [SZ_W-1:0]   rem,
   input  logic [IDXW_W-1:0] nbits,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] ent_addr
);
   generate
      if (IDXW_W >= SZ_W) begin : g_bad_w
         $error("rw_index_gen: index width field must be narrower than size field");
      end
   endgenerate

   logic [SZ_W-1:0]   shamt;
   logic [ADDR_W-1:0] idx_mask;
   logic [ADDR_W-1:0] idx;

   always_comb begin
      shamt    = rem - SZ_W'(nbits);
      idx_mask = (ADDR_W'(1) << nbits) - ADDR_W'(1);
      idx      = (ea >> shamt) & idx_mask;
      ent_addr = base + (idx << ENT_LOG2);
   end
endmodule

// File: rtl/rw_leaf_merge.sv
module rw_leaf_merge #(
   parameter int ADDR_W = 64,
   parameter int SZ_W   = 6
) (
   input  logic [ADDR_W-1:0] ea,
   input  logic [ADDR_W-1:0] page_num,
   input  logic [SZ_W-1:0]   shift,
   output logic [ADDR_W-1:0] real_addr
);
   generate
      if (ADDR_W > (1 << SZ_W)) begin : g_bad_w
         $error("rw_leaf_merge: size field cannot span the address");
      end
   endgenerate

   logic [ADDR_W-1:0] low_mask;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
      assign low_mask[i] = (shift > SZ_W'(i));
   end

   assign real_addr = (page_num & ~low_mask) | (ea & low_mask);
endmodule

// File: rtl/rw_radix_walker.sv
module rw_radix_walker
   import rw_pkg::*;
#(
   parameter int PID_W        = 20,
   parameter int MAX_LEVELS   = 8,
   parameter int PTE_BYTES    = 16,
   parameter int MIN_IDX_BITS = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [ENTRY_W-1:0]   req_ea,
   input  logic [PID_W-1:0]     req_pid,
   input  logic [ENTRY_W-1:0]   ptab_base,
   input  logic [4:0]           ptab_size,
   output logic                 busy,
   output logic                 mem_req,
   output logic [ENTRY_W-1:0]   mem_addr,
   input  logic                 mem_rvalid,
   input  logic [ENTRY_W-1:0]   mem_rdata,
   output logic                 done,
   output logic                 fault,
   output logic [CAUSE_W-1:0]   fault_cause,
   output logic [ENTRY_W-1:0]   real_addr,
   output logic [SZ_W-1:0]      page_shift,
   output logic [ENTRY_W-1:0]   leaf_entry,
   output logic [ENTRY_W-1:0]   leaf_addr
);
   localparam int PTE_LOG2 = $clog2(PTE_BYTES);
   localparam int LVL_W    = $clog2(MAX_LEVELS + 1);

   generate
      if (PTE_BYTES != (1 << PTE_LOG2) || PTE_BYTES < 8) begin : g_bad_pte
         $error("rw_radix_walker: PTE_BYTES must be a power of two of at least 8");
      end
      if (MAX_LEVELS < 1) begin : g_bad_lvl
         $error("rw_radix_walker: MAX_LEVELS must be positive");
      end
      if (MIN_IDX_BITS < 1 || MIN_IDX_BITS >= (1 << IDXW_W)) begin : g_bad_min
         $error("rw_radix_walker: MIN_IDX_BITS out of range");
      end
   endgenerate

   walk_state_t         state_q;
   logic [ENTRY_W-1:0]  ea_q, base_q, addr_q;
   logic [IDXW_W-1:0]   nbits_q;
   logic [SZ_W-1:0]     rem_q;
   logic [LVL_W-1:0]    lvl_q;

   logic                pid_ok;
   logic [ENTRY_W-1:0]  pid_off;
   logic [ENTRY_W-1:0]  lvl_addr;
   logic [SZ_W-1:0]     rem_next;
   logic [ENTRY_W-1:0]  merged_ra;
   logic                cfg_bad;

   rw_ptab_bound #(.PID_W(PID_W), .PTE_LOG2(PTE_LOG2), .ADDR_W(ENTRY_W)) u_bound (
      .pid       (req_pid),
      .size_code (ptab_size),
      .in_range  (pid_ok),
      .offset    (pid_off)
   );

   rw_index_gen #(.ADDR_W(ENTRY_W), .SZ_W(SZ_W), .IDXW_W(IDXW_W), .ENT_LOG2(ENT_LOG2)) u_index (
      .ea       (ea_q),
      .rem      (rem_q),
      .nbits    (nbits_q),
      .base     (base_q),
      .ent_addr (lvl_addr)
   );

   assign rem_next = rem_q - SZ_W'(nbits_q);

   rw_leaf_merge #(.ADDR_W(ENTRY_W), .SZ_W(SZ_W)) u_merge (
      .ea        (ea_q),
      .page_num  (mem_rdata & PN_MASK),
      .shift     (rem_next),
      .real_addr (merged_ra)
   );

   assign cfg_bad = (nbits_q < IDXW_W'(MIN_IDX_BITS))
                 || (SZ_W'(nbits_q) > rem_q)
                 || (lvl_q == LVL_W'(MAX_LEVELS));

   assign busy     = (state_q != ST_IDLE);
   assign mem_req  = (state_q == ST_PTAB) || (state_q == ST_LEVEL);
   assign mem_addr = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         ea_q        <= '0;
         base_q      <= '0;
         addr_q      <= '0;
         nbits_q     <= '0;
         rem_q       <= '0;
         lvl_q       <= '0;
         done        <= 1'b0;
         fault       <= 1'b0;
         fault_cause <= '0;
         real_addr   <= '0;
         page_shift  <= '0;
         leaf_entry  <= '0;
         leaf_addr   <= '0;
      end else begin
         done  <= 1'b0;
         fault <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  ea_q <= req_ea;
                  if (!pid_ok) begin
                     fault       <= 1'b1;
                     fault_cause <= CAUSE_NOENT;
                  end else begin
                     addr_q  <= ptab_base + pid_off;
                     state_q <= ST_PTAB;
                  end
               end
            end
            ST_PTAB: begin
               if (mem_rvalid) begin
                  rem_q   <= mem_rdata[TOT_LSB +: SZ_W];
                  base_q  <= mem_rdata & BASE_MASK;
                  nbits_q <= mem_rdata[IDXW_W-1:0];
                  lvl_q   <= '0;
                  state_q <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (cfg_bad) begin
                  fault       <= 1'b1;
                  fault_cause <= CAUSE_BADCFG;
                  state_q     <= ST_IDLE;
               end else begin
                  addr_q  <= lvl_addr;
                  state_q <= ST_LEVEL;
               end
            end
            ST_LEVEL: begin
               if (mem_rvalid) begin
                  if (!mem_rdata[VALID_BIT]) begin
                     fault       <= 1'b1;
                     fault_cause <= CAUSE_NOENT;
                     state_q     <= ST_IDLE;
                  end else if (mem_rdata[LEAF_BIT]) begin
                     done       <= 1'b1;
                     real_addr  <= merged_ra;
                     page_shift <= rem_next;
                     leaf_entry <= mem_rdata;
                     leaf_addr  <= addr_q;
                     state_q    <= ST_IDLE;
                  end else begin
                     rem_q   <= rem_next;
                     base_q  <= mem_rdata & BASE_MASK;
                     nbits_q <= mem_rdata[IDXW_W-1:0];
                     lvl_q   <= lvl_q + LVL_W'(1);
                     state_q <= ST_CHECK;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rw_radix_walker_chk.sv
module rw_radix_walker_chk
   import rw_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                mem_req,
   input logic [ENTRY_W-1:0]  mem_addr,
   input logic                mem_rvalid,
   input logic                done,
   input logic                fault,
   input logic [CAUSE_W-1:0]  fault_cause,
   input logic [ENTRY_W-1:0]  leaf_entry
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   assert_end_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fault) |-> !busy);

   assert_end_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   assert_cause_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> ($countones(fault_cause) == 1));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_leaf_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (leaf_entry[VALID_BIT] && leaf_entry[LEAF_BIT]));
endmodule

bind rw_radix_walker rw_radix_walker_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .mem_req     (mem_req),
   .mem_addr    (mem_addr),
   .mem_rvalid  (mem_rvalid),
   .done        (done),
   .fault       (fault),
   .fault_cause (fault_cause),
   .leaf_entry  (leaf_entry)
);

// File: tb/sim_rw_radix_walker.sv
module sim_rw_radix_walker;
   localparam int CLK_PERIOD = 10;
   localparam int PID_W      = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_ea = '0;
   logic [PID_W-1:0] req_pid = '0;
   logic [63:0] ptab_base = '0;
   logic [4:0]  ptab_size = '0;
   logic        busy, mem_req, done, fault;
   logic [63:0] mem_addr, real_addr, leaf_entry, leaf_addr;
   logic        mem_rvalid;
   logic [63:0] mem_rdata;
   logic [1:0]  fault_cause;
   logic [5:0]  page_shift;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rw_radix_walker #(.PID_W(PID_W)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
      .req_pid(req_pid), .ptab_base(ptab_base), .ptab_size(ptab_size),
      .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
      .fault(fault), .fault_cause(fault_cause), .real_addr(real_addr),
      .page_shift(page_shift), .leaf_entry(leaf_entry), .leaf_addr(leaf_addr)
   );

   // memory model: answers each held request two cycles after it appears
   logic [63:0] mem [logic [63:0]];
   int          nreads = 0;
   logic        pend = 1'b0;
   int          cnt = 0;

   function automatic logic [63:0] rd(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rvalid <= 1'b0;
         mem_rdata  <= '0;
         pend       <= 1'b0;
      end else begin
         mem_rvalid <= 1'b0;
         if (pend) begin
            if (cnt == 0) begin
               mem_rvalid <= 1'b1;
               mem_rdata  <= rd(mem_addr);
               pend       <= 1'b0;
               nreads     <= nreads + 1;
            end else cnt <= cnt - 1;
         end else if (mem_req && !mem_rvalid) begin
            pend <= 1'b1;
            cnt  <= 1;
         end
      end
   end

   // entry encodings from R3, R6, R7, R8
   function automatic logic [63:0] mk_dir(input logic [63:0] b, input int n);
      return 64'h8000_0000_0000_0000 | (b & 64'h00FF_FFFF_FFFF_FF00) | 64'(n);
   endfunction
   function automatic logic [63:0] mk_leaf(input logic [63:0] pn);
      return 64'hC000_0000_0000_0000 | (pn & 64'h00FF_FFFF_FFFF_F000) | 64'h0A5;
   endfunction
   function automatic logic [63:0] mk_pt(input int tot, input logic [63:0] b, input int n);
      return (64'(tot) << 56) | (b & 64'h00FF_FFFF_FFFF_FF00) | 64'(n);
   endfunction
   function automatic logic [63:0] ent_at(input logic [63:0] b, input logic [63:0] ea,
                                          input int rem, input int n);
      return b + (((ea >> (rem - n)) & ((64'd1 << n) - 64'd1)) << 3);
   endfunction
   function automatic logic [63:0] merge(input logic [63:0] leaf, input logic [63:0] ea,
                                         input int sh);
      logic [63:0] m;
      m = (64'd1 << sh) - 64'd1;
      return ((leaf & 64'h00FF_FFFF_FFFF_F000) & ~m) | (ea & m);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic start(input logic [63:0] ea, input int pid);
      @(negedge clk);
      req_ea    = ea;
      req_pid   = PID_W'(pid);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 400; i++) begin
         if (done || fault) break;
         @(negedge clk);
      end
   endtask

   task automatic fresh(input logic [63:0] pb, input int sz);
      mem.delete();
      ptab_base = pb;
      ptab_size = 5'(sz);
   endtask

   // four-level tree, page 12; optionally level-3 entry missing
   task automatic build4(input logic [63:0] ea, input int pid, input bit hole,
                         output logic [63:0] leaf, output logic [63:0] laddr);
      logic [63:0] a;
      fresh(64'h10000, 0);
      mem[64'h10000 + 64'(pid) * 16] = mk_pt(52, 64'h20000, 13);
      a = ent_at(64'h20000, ea, 52, 13); mem[a] = mk_dir(64'h40000, 9);
      a = ent_at(64'h40000, ea, 39, 9);  mem[a] = mk_dir(64'h50000, 9);
      if (!hole) begin
         a = ent_at(64'h50000, ea, 30, 9); mem[a] = mk_dir(64'h60000, 9);
      end
      laddr = ent_at(64'h60000, ea, 21, 9);
      leaf  = mk_leaf(64'h0000_1234_5678_9000);
      mem[laddr] = leaf;
   endtask

   task automatic t_reset();
      chk("R1 busy", 64'(busy), 0);
      chk("R1 done", 64'(done), 0);
      chk("R1 fault", 64'(fault), 0);
      chk("R1 mem_req", 64'(mem_req), 0);
   endtask

   task automatic t_four_level();
      logic [63:0] ea, leaf, la;
      int r0;
      ea = 64'h000A_BCDE_F123_4567;
      build4(ea, 3, 0, leaf, la);
      r0 = nreads;
      start(ea, 3); wait_end();
      chk("R7 done", 64'(done), 1);
      chk("R7 real_addr", real_addr, merge(leaf, ea, 12));
      chk("R7 page_shift", 64'(page_shift), 12);
      chk("R7 leaf_entry", leaf_entry, leaf);
      chk("R4 leaf_addr", leaf_addr, la);
      chk("R8 reads", 64'(nreads - r0), 5);
   endtask

   task automatic t_big_page();
      logic [63:0] ea, leaf, a;
      ea = 64'h0000_00AB_CDEF_1234;
      fresh(64'h30000, 2);
      mem[64'h30000] = mk_pt(40, 64'h70000, 10);
      a = ent_at(64'h70000, ea, 40, 10); mem[a] = mk_dir(64'h80000, 9);
      a = ent_at(64'h80000, ea, 30, 9);
      leaf = mk_leaf(64'h0000_0007_8000_0000);
      mem[a] = leaf;
      start(ea, 0); wait_end();
      chk("R7 big done", 64'(done), 1);
      chk("R7 big page_shift", 64'(page_shift), 21);
      chk("R7 big real_addr", real_addr, merge(leaf, ea, 21));
      chk("R3 big leaf_addr", leaf_addr, a);
   endtask

   task automatic t_invalid();
      logic [63:0] ea, leaf, la;
      int r0;
      ea = 64'h0003_1111_2222_3333;
      build4(ea, 5, 1, leaf, la);
      r0 = nreads;
      start(ea, 5); wait_end();
      chk("R6 fault", 64'(fault), 1);
      chk("R6 cause", 64'(fault_cause), 1);
      chk("R6 reads", 64'(nreads - r0), 4);
   endtask

   task automatic t_pid_bound();
      logic [63:0] ea;
      int r0;
      ea = 64'h0000_0000_0000_1000;
      fresh(64'h10000, 0);
      mem[64'h10000 + 64'(255) * 16] = mk_pt(52, 64'h20000, 13);
      r0 = nreads;
      start(ea, 256);
      chk("R2 oob fault", 64'(fault), 1);
      chk("R2 oob cause", 64'(fault_cause), 1);
      repeat (4) @(negedge clk);
      chk("R2 oob no read", 64'(nreads - r0), 0);
      r0 = nreads;
      start(ea, 255); wait_end();
      chk("R2 last pid cause", 64'(fault_cause), 1);
      chk("R2 last pid reads", 64'(nreads - r0), 2);
   endtask

   task automatic t_small_index();
      logic [63:0] ea, a;
      int r0;
      ea = 64'h0000_0000_00AB_C000;
      fresh(64'h10000, 0);
      mem[64'h10000] = mk_pt(52, 64'h20000, 4);
      r0 = nreads;
      start(ea, 0); wait_end();
      chk("R5 root small cause", 64'(fault_cause), 2);
      chk("R5 root small reads", 64'(nreads - r0), 1);
      mem[64'h10000] = mk_pt(52, 64'h20000, 13);
      a = ent_at(64'h20000, ea, 52, 13); mem[a] = mk_dir(64'h40000, 4);
      r0 = nreads;
      start(ea, 0); wait_end();
      chk("R5 inner small cause", 64'(fault_cause), 2);
      chk("R5 inner small reads", 64'(nreads - r0), 2);
      mem[64'h10000] = mk_pt(10, 64'h20000, 11);
      r0 = nreads;
      start(ea, 0); wait_end();
      chk("R5 wide index cause", 64'(fault_cause), 2);
      chk("R5 wide index reads", 64'(nreads - r0), 1);
   endtask

   task automatic t_depth(input bit end_leaf);
      logic [63:0] ea, a, leaf;
      int r0;
      ea = 64'h7FFF_FFFF_FFFF_FFFF;
      fresh(64'h10000, 0);
      mem[64'h10000] = mk_pt(63, 64'h100000, 5);
      leaf = mk_leaf(64'h0000_00AA_0000_0000);
      for (int k = 0; k < 8; k++) begin
         a = ent_at(64'h100000 + 64'(k) * 64'h1000, ea, 63 - 5*k, 5);
         if (end_leaf && k == 7) mem[a] = leaf;
         else mem[a] = mk_dir(64'h100000 + 64'(k+1) * 64'h1000, 5);
      end
      r0 = nreads;
      start(ea, 0); wait_end();
      if (end_leaf) begin
         chk("R9 eight levels done", 64'(done), 1);
         chk("R9 eight levels shift", 64'(page_shift), 23);
         chk("R9 eight levels ra", real_addr, merge(leaf, ea, 23));
      end else begin
         chk("R9 too deep cause", 64'(fault_cause), 2);
         chk("R9 too deep reads", 64'(nreads - r0), 9);
      end
   endtask

   task automatic t_busy();
      logic [63:0] ea, leaf, la;
      int r0;
      ea = 64'h0001_2345_6789_ABCD;
      build4(ea, 7, 0, leaf, la);
      r0 = nreads;
      start(ea, 7);
      chk("R10 busy", 64'(busy), 1);
      start(64'h0009_9999_9999_9999, 1);
      wait_end();
      chk("R10 first wins", real_addr, merge(leaf, ea, 12));
      chk("R10 reads", 64'(nreads - r0), 5);
      @(negedge clk);
      chk("R11 done pulse", 64'(done), 0);
      chk("R10 idle", 64'(busy), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_four_level();
      t_big_page();
      t_invalid();
      t_pid_bound();
      t_small_index();
      t_depth(1'b1);
      t_depth(1'b0);
      t_busy();
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule